// File: doc/BRIEF.md
# Alarm-Started Periodic Pulse Generator

This block turns a running 64-bit nanosecond time value into three periodic pulse trains. Each train begins at a programmed absolute time: two 64-bit alarm comparators watch the time input, and each pulse channel picks one of them as its start trigger. Once triggered, a channel fires at the alarm time and then once every programmed interval plus one tick period. Each firing drives the channel's pulse line high for a number of prescaled output-clock cycles.

Software programs the block through a narrow write port. The alarms are 64 bits wide and are loaded as two 32-bit halves through a shadow, low half first. All three channels share one control word, with one byte per channel. Every alarm match and every channel firing produces a one-cycle strobe on a 32-bit event vector, at fixed bit positions that downstream event logic decodes.

Top module: `apg_top`

## Requirements
- R1: After synchronous reset all pulse lines are low and no event strobe is raised. Both alarms hold all ones, which means idle. Every channel's disable bit is set, and every interval holds all ones.
- R2: Write address 0 (alarm 0) or 2 (alarm 1) loads only the shadow low half and has no visible effect. Write address 1 or 3 commits {data, shadow} as the new 64-bit alarm value.
- R3: An alarm whose value is not all ones strobes event bit 16+j one cycle after the first cycle in which time is at or above its value. It stays quiet after that until it is committed again.
- R4: Channel i is armed only by the alarm its control bit 5 selects (0 = alarm 0, 1 = alarm 1). Its first firing is at the alarm value.
- R5: Each firing of channel i strobes event bit 7-i. Later firings follow whenever time reaches the previous target plus the interval (addresses 5+i) plus the tick period input.
- R6: On each firing the pulse line goes high when width bits 4:0 are nonzero. It returns low at the clock edge of the width-th following cycle that has prescale enable set.
- R7: While the disable bit 7 is set, the channel's pulse line is low from the next cycle. It clears its armed state, raises no events and ignores alarms.
- R8: A channel whose interval register holds all ones behaves as disabled.
- R9: When the gate bit 6 is set, the pulse line stays low, but firings and their events continue.
- R10: The control word at address 4 carries channel i's configuration in byte i (bits 8i+7 to 8i).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register address |
| wr_data | input | 32 | Register write data |
| time_i | input | 64 | Running time value in ns |
| tick_ns | input | 10 | Integer tick period in ns |
| ps_en | input | 1 | Prescaled output-clock enable |
| pulse_o | output | 3 | Pulse lines, bit i for channel i |
| evt_o | output | 32 | One-cycle event strobes |

## Verification
The hardest state to reach is a disable that arrives while a pulse is already high on an armed channel. The test must then show that a later alarm match does not restart that channel. The stimulus waits for the channel-0 line to rise and writes the disable bit at once. It then recommits alarm 0, re-enables the channel with a 31-cycle width and recommits alarm 0 again to measure the full width. A behavioural model of every strobe and pulse line is compared on each clock throughout.

// File: rtl/apg_pkg.sv
package apg_pkg;
    localparam int NCH   = 3;
    localparam int NALM  = 2;
    localparam int TW    = 64;
    localparam int PW_W  = 5;
    localparam int IV_W  = 32;
    localparam int AW    = 3;
    localparam int DW    = 32;
    localparam int EVW   = 32;
    localparam int CW    = NCH * 8;

    localparam logic [AW-1:0] A_ALM_BASE = 3'd0;
    localparam logic [AW-1:0] A_CTRL     = 3'd4;
    localparam logic [AW-1:0] A_IV_BASE  = 3'd5;

    typedef struct packed {
        logic            dis;
        logic            gate;
        logic            alm_sel;
        logic [PW_W-1:0] width;
    } chan_cfg_t;

    function automatic int alm_evt_bit(input int j);
        return 16 + j;
    endfunction

    function automatic int ch_evt_bit(input int i);
        return 7 - i;
    endfunction
endpackage

// File: rtl/apg_regs.sv
module apg_regs
    import apg_pkg::*;
(
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      wr_en,
    input  logic [AW-1:0]             wr_addr,
    input  logic [DW-1:0]             wr_data,
    output logic [NALM-1:0][TW-1:0]   alm_val,
    output logic [NALM-1:0]           alm_commit,
    output logic [CW-1:0]             ctrl,
    output logic [NCH-1:0][IV_W-1:0]  ival
);
    logic [NALM-1:0][DW-1:0] shadow_q;

    for (genvar j = 0; j < NALM; j++) begin : g_alm
        localparam logic [AW-1:0] LO = A_ALM_BASE + AW'(2*j);
        localparam logic [AW-1:0] HI = A_ALM_BASE + AW'(2*j + 1);
        assign alm_commit[j] = wr_en && (wr_addr == HI);
        always_ff @(posedge clk) begin
            if (rst) begin
                shadow_q[j] <= '0;
                alm_val[j]  <= '1;
            end else begin
                if (wr_en && wr_addr == LO) shadow_q[j] <= wr_data;
                if (alm_commit[j])          alm_val[j]  <= {wr_data, shadow_q[j]};
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NCH; i++) ctrl[8*i +: 8] <= 8'h80;
        end else if (wr_en && wr_addr == A_CTRL) begin
            ctrl <= wr_data[CW-1:0];
        end
    end

    for (genvar i = 0; i < NCH; i++) begin : g_iv
        always_ff @(posedge clk) begin
            if (rst)                                        ival[i] <= '1;
            else if (wr_en && wr_addr == A_IV_BASE + AW'(i)) ival[i] <= wr_data;
        end
    end
endmodule

// File: rtl/apg_alarm.sv
module apg_alarm
    import apg_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic [TW-1:0] time_i,
    input  logic [TW-1:0] val_i,
    input  logic          commit_i,
    output logic          hit_o
);
    logic fired_q;
    logic match;

    assign match = !(&val_i) && !fired_q && (time_i >= val_i);

    always_ff @(posedge clk) begin
        if (rst) begin
            fired_q <= 1'b0;
            hit_o   <= 1'b0;
        end else begin
            hit_o <= match;
            if (commit_i)   fired_q <= 1'b0;
            else if (match) fired_q <= 1'b1;
        end
    end

    assert_alarm_once_R3: assert property (@(posedge clk) disable iff (rst)
        (hit_o && !$past(commit_i)) |=> !hit_o);
endmodule

// File: rtl/apg_channel.sv
module apg_channel
    import apg_pkg::*;
#(
    parameter int TICK_W = 10
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [TW-1:0]     time_i,
    input  logic [TICK_W-1:0] tick_i,
    input  logic              ps_en_i,
    input  chan_cfg_t         cfg_i,
    input  logic [IV_W-1:0]   ival_i,
    input  logic              trig_i,
    input  logic [TW-1:0]     trig_time_i,
    output logic              fire_o,
    output logic              pulse_o
);
    logic            armed_q;
    logic [TW-1:0]   next_q;
    logic            out_q;
    logic [PW_W-1:0] cnt_q;
    logic            enabled;
    logic            due;
    logic [TW-1:0]   step;

    assign enabled = !cfg_i.dis && !(&ival_i);
    assign due     = armed_q && (time_i >= next_q);
    assign step    = TW'(ival_i) + TW'(tick_i);

    always_ff @(posedge clk) begin
        if (rst || !enabled) begin
            armed_q <= 1'b0;
            next_q  <= '0;
            out_q   <= 1'b0;
            cnt_q   <= '0;
            fire_o  <= 1'b0;
        end else begin
            fire_o <= due;
            if (trig_i) begin
                armed_q <= 1'b1;
                next_q  <= trig_time_i;
            end else if (due) begin
                next_q  <= next_q + step;
            end
            if (due) begin
                out_q <= (cfg_i.width != '0);
                cnt_q <= cfg_i.width;
            end else if (out_q && ps_en_i) begin
                if (cnt_q <= PW_W'(1)) begin
                    out_q <= 1'b0;
                    cnt_q <= '0;
                end else begin
                    cnt_q <= cnt_q - PW_W'(1);
                end
            end
        end
    end

    assign pulse_o = out_q && !cfg_i.dis && !cfg_i.gate;

    assert_disable_quiet_R7: assert property (@(posedge clk) disable iff (rst)
        cfg_i.dis |=> (!fire_o && !pulse_o));

    assert_ones_interval_idle_R8: assert property (@(posedge clk) disable iff (rst)
        (&ival_i) |=> !fire_o);

    assert_arm_from_trigger_R4: assert property (@(posedge clk) disable iff (rst)
        $rose(armed_q) |-> $past(trig_i));
endmodule

// File: rtl/apg_top.sv
module apg_top
    import apg_pkg::*;
#(
    parameter int TICK_W = 10
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [AW-1:0]     wr_addr,
    input  logic [DW-1:0]     wr_data,
    input  logic [TW-1:0]     time_i,
    input  logic [TICK_W-1:0] tick_ns,
    input  logic              ps_en,
    output logic [NCH-1:0]    pulse_o,
    output logic [EVW-1:0]    evt_o
);
    logic [NALM-1:0][TW-1:0]  alm_val;
    logic [NALM-1:0]          alm_commit;
    logic [NALM-1:0]          alm_hit;
    logic [CW-1:0]            ctrl;
    logic [NCH-1:0][IV_W-1:0] ival;
    logic [NCH-1:0]           ch_fire;

    apg_regs u_regs (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .alm_val(alm_val), .alm_commit(alm_commit), .ctrl(ctrl), .ival(ival)
    );

    for (genvar j = 0; j < NALM; j++) begin : g_alarm
        apg_alarm u_alm (
            .clk(clk), .rst(rst), .time_i(time_i), .val_i(alm_val[j]),
            .commit_i(alm_commit[j]), .hit_o(alm_hit[j])
        );
    end

    for (genvar i = 0; i < NCH; i++) begin : g_chan
        chan_cfg_t cfg;
        assign cfg = chan_cfg_t'(ctrl[8*i +: 8]);
        apg_channel #(.TICK_W(TICK_W)) u_ch (
            .clk(clk), .rst(rst), .time_i(time_i), .tick_i(tick_ns), .ps_en_i(ps_en),
            .cfg_i(cfg), .ival_i(ival[i]),
            .trig_i(alm_hit[cfg.alm_sel]), .trig_time_i(alm_val[cfg.alm_sel]),
            .fire_o(ch_fire[i]), .pulse_o(pulse_o[i])
        );
    end

    always_comb begin
        evt_o = '0;
        for (int j = 0; j < NALM; j++) evt_o[alm_evt_bit(j)] = alm_hit[j];
        for (int i = 0; i < NCH; i++)  evt_o[ch_evt_bit(i)]  = ch_fire[i];
    end
endmodule

// File: tb/tb_apg_top.sv
module tb_apg_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic [63:0] time_i = 64'd1000;
    logic [9:0]  tick_ns = 10'd8;
    logic        ps_en = 1'b0;
    logic [2:0]  pulse_o;
    logic [31:0] evt_o;

    always #2 clk = ~clk;

    apg_top dut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .time_i(time_i), .tick_ns(tick_ns), .ps_en(ps_en), .pulse_o(pulse_o), .evt_o(evt_o)
    );

    int n_cmp = 0, n_bad = 0;

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Behavioural reference model
    longint unsigned m_alm[2], m_sh[2], m_iv[3], m_nxt[3];
    bit m_fired[2], m_aevt[2], m_arm[3], m_fire[3], m_out[3];
    bit [31:0] m_ctrl;
    int m_cnt[3];

    always @(posedge clk) begin
        if (rst) begin
            for (int j = 0; j < 2; j++) begin
                m_alm[j] = 64'hFFFF_FFFF_FFFF_FFFF; m_sh[j] = 0; m_fired[j] = 0; m_aevt[j] = 0;
            end
            for (int i = 0; i < 3; i++) begin
                m_iv[i] = 64'hFFFF_FFFF; m_nxt[i] = 0; m_arm[i] = 0; m_fire[i] = 0; m_out[i] = 0; m_cnt[i] = 0;
            end
            m_ctrl = 32'h0080_8080;
        end else begin
            for (int i = 0; i < 3; i++) begin
                bit dis, sel, hit;
                int w;
                dis = m_ctrl[8*i+7]; sel = m_ctrl[8*i+5]; w = int'(m_ctrl[8*i +: 5]);
                if (dis || m_iv[i] == 64'hFFFF_FFFF) begin
                    m_arm[i] = 0; m_out[i] = 0; m_cnt[i] = 0; m_fire[i] = 0; m_nxt[i] = 0;
                end else begin
                    hit = m_arm[i] && (time_i >= m_nxt[i]);
                    m_fire[i] = hit;
                    if (m_aevt[sel]) begin m_arm[i] = 1; m_nxt[i] = m_alm[sel]; end
                    else if (hit) m_nxt[i] = m_nxt[i] + m_iv[i] + tick_ns;
                    if (hit) begin m_out[i] = (w != 0); m_cnt[i] = w; end
                    else if (m_out[i] && ps_en) begin
                        if (m_cnt[i] <= 1) begin m_out[i] = 0; m_cnt[i] = 0; end
                        else m_cnt[i]--;
                    end
                end
            end
            for (int j = 0; j < 2; j++) begin
                bit mt;
                mt = (m_alm[j] != 64'hFFFF_FFFF_FFFF_FFFF) && !m_fired[j] && (time_i >= m_alm[j]);
                m_aevt[j] = mt;
                if (mt) m_fired[j] = 1;
            end
            if (wr_en) begin
                case (wr_addr)
                    3'd0: m_sh[0] = wr_data;
                    3'd1: begin m_alm[0] = {wr_data, m_sh[0][31:0]}; m_fired[0] = 0; end
                    3'd2: m_sh[1] = wr_data;
                    3'd3: begin m_alm[1] = {wr_data, m_sh[1][31:0]}; m_fired[1] = 0; end
                    3'd4: m_ctrl = {8'h00, wr_data[23:0]};
                    default: m_iv[wr_addr - 3'd5] = wr_data;
                endcase
            end
        end
    end

    // Per-clock comparison and observation counters
    int ch_cnt[3], al_cnt[2];
    int ch0_early = 0, p1_high = 0, run0 = 0, last_run0 = 0;
    longint unsigned ch0_first = 0, ch0_last = 0;

    always @(negedge clk) begin
        if (!rst) begin
            for (int i = 0; i < 3; i++) begin
                bit ep;
                ep = m_out[i] && !m_ctrl[8*i+7] && !m_ctrl[8*i+6];
                chk(pulse_o[i] == ep, "R6 pulse line", pulse_o[i], ep);
                chk(evt_o[7-i] == m_fire[i], "R5 channel event", evt_o[7-i], m_fire[i]);
            end
            for (int j = 0; j < 2; j++)
                chk(evt_o[16+j] == m_aevt[j], "R3 alarm event", evt_o[16+j], m_aevt[j]);
            for (int j = 0; j < 2; j++) if (evt_o[16+j]) al_cnt[j]++;
            for (int i = 0; i < 3; i++) if (evt_o[7-i]) ch_cnt[i]++;
            if (evt_o[7]) begin
                if (al_cnt[0] == 0) ch0_early++;
                if (ch_cnt[0] == 1) ch0_first = time_i;
                ch0_last = time_i;
            end
            if (pulse_o[1]) p1_high++;
            if (pulse_o[0]) run0++;
            else if (run0 > 0) begin last_run0 = run0; run0 = 0; end
        end
        time_i = time_i + 64'(tick_ns);
        ps_en  = ~ps_en;
    end

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    bit done = 0;

    initial begin
        int c0, c1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(pulse_o == 3'b000, "R1 pulses after reset", pulse_o, 0);
        chk(evt_o == 32'h0, "R1 events after reset", evt_o, 0);

        wr(3'd0, 32'd50);
        repeat (8) @(negedge clk);
        chk(al_cnt[0] == 0, "R2 low-half write alone", al_cnt[0], 0);

        wr(3'd5, 32'd92);
        wr(3'd6, 32'd192);
        wr(3'd4, 32'h0024_6503);
        wr(3'd0, 32'(time_i + 400)); wr(3'd1, 32'd0);
        wr(3'd2, 32'(time_i + 600)); wr(3'd3, 32'd0);
        repeat (150) @(negedge clk);

        chk(ch0_early == 0, "R4 channel 0 fires only after alarm 0", ch0_early, 0);
        chk(al_cnt[0] == 1, "R3 alarm 0 single event", al_cnt[0], 1);
        chk(al_cnt[1] == 1, "R3 alarm 1 single event", al_cnt[1], 1);
        chk(ch_cnt[0] >= 5, "R5 channel 0 repeats", ch_cnt[0], 5);
        begin
            longint unsigned avg;
            avg = (ch_cnt[0] > 1) ? (ch0_last - ch0_first) / longint'(ch_cnt[0] - 1) : 0;
            chk(avg >= 96 && avg <= 104, "R5 mean spacing interval+tick", avg, 100);
        end
        chk(ch_cnt[1] > 0, "R9 gated channel still fires", ch_cnt[1], 1);
        chk(p1_high == 0, "R9 gated pulse line low", p1_high, 0);
        chk(ch_cnt[2] == 0, "R8 all-ones interval idle", ch_cnt[2], 0);

        while (!pulse_o[0]) @(negedge clk);
        wr(3'd4, 32'h0024_6583);
        chk(pulse_o[0] == 1'b0, "R7 disable drops pulse at once", pulse_o[0], 0);
        c0 = ch_cnt[0];
        c1 = ch_cnt[1];
        wr(3'd0, 32'(time_i + 100)); wr(3'd1, 32'd0);
        repeat (60) @(negedge clk);
        chk(ch_cnt[0] == c0, "R7 disabled channel ignores alarm", ch_cnt[0], c0);
        chk(al_cnt[0] == 2, "R3 recommitted alarm fires again", al_cnt[0], 2);

        wr(3'd5, 32'd2000);
        wr(3'd4, 32'h0024_651F);
        wr(3'd0, 32'(time_i + 200)); wr(3'd1, 32'd0);
        repeat (300) @(negedge clk);
        chk(last_run0 >= 61 && last_run0 <= 62, "R6 width 31 prescaled cycles", last_run0, 62);
        chk(ch_cnt[1] > c1, "R10 byte 1 kept across byte 0 change", ch_cnt[1], c1 + 1);
        chk(ch_cnt[0] > c0, "R10 channel 0 re-armed by its byte", ch_cnt[0], c0 + 1);

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog R1 actual=%0d expected=%0d", 0, 1);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule